// File: doc/BRIEF.md
# ROM Wait-State Sequencer

This block paces reads from an external ROM. For each access it works out how many wait states the ROM needs, whether an address-decode cycle comes first, and when the data phase ends. It serves instruction fetches and data reads. The ROM port can be an 8-bit plain port, a 16-bit plain port or a 16-bit port split into two interleaved banks. The cache storage and the ROM device are outside this block.

An accepted request is either a cache line fill or a plain access. A line fill is an instruction fetch with the cache on and a miss reported. It runs a fixed number of beats. A plain access is a data read, an uncached fetch, or a fetch with a cache hit. It runs one beat, and it keeps going beat by beat at consecutive addresses while the sequential flag is high. On an interleaved port, the wait count of each beat depends on where the beat falls inside an aligned group of eight addresses. The first beat of the group takes the full count `w`. Odd slots take the short count `s`. The other even slots take `w-s-1`, clamped from below.

Top module: `rom_wait_sequencer`

## Requirements
- R1: With `port_mode` 2'b00 (8-bit plain port), a line fill runs 16 beats and every beat waits `w_cfg` cycles.
- R2: With `port_mode` 2'b01 (16-bit plain port), a line fill runs 8 beats and every beat waits `w_cfg` cycles.
- R3: On a plain port, a plain access waits `w_cfg` cycles on every beat. This holds for data reads, for fetches with the cache off and for fetches that hit. The cache flags change nothing for data reads.
- R4: Only the first beat of a fill or run has a decode cycle, and `decode_cycle` is high in that beat's first cycle only. A beat lasts decode (0 or 1) + wait + 1 cycles. `beat_wait` holds steady for the whole beat, and `beat_done` is high in the beat's last cycle only.
- R5: With `port_mode[1]` = 1 (interleaved port), a beat at group slot 0 waits `w_cfg`, a beat at an odd slot waits `s_cfg`, and a beat at slot 2, 4 or 6 waits `w_cfg - s_cfg - 1` after clamping. An interleaved fill runs 8 beats at slots 0 to 7.
- R6: In an interleaved line fill, `w_cfg - s_cfg - 1` is raised to 1 when it would be below 1.
- R7: In an interleaved plain access, `w_cfg - s_cfg - 1` is raised to `s_cfg` when it would be below `s_cfg`.
- R8: An interleaved plain run starts at slot `addr[2:0]`. Each following beat moves up one address, and the slot wraps back to 0 (full `w_cfg`) at every 8-aligned address.
- R9: A plain run ends at whatever beat has `seq` low in its `beat_done` cycle, at any address. `burst_done` pulses for one cycle, in the cycle right after the last beat's `beat_done`.
- R10: The block captures the mode, `w_cfg`, `s_cfg`, the address and the flags when it accepts `req` while idle. From then until `burst_done`, it ignores `req` and any change on those inputs.
- R11: After reset, and whenever the block is idle, `beat_done`, `decode_cycle` and `burst_done` are low and `beat_wait` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request, accepted when idle |
| addr | input | AW | Request address (access units) |
| is_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| cache_en | input | 1 | Instruction cache enabled |
| cache_miss | input | 1 | Instruction cache missed |
| seq | input | 1 | Continue the plain run, sampled in each `beat_done` cycle |
| port_mode | input | 2 | 00 8-bit plain, 01 16-bit plain, 1x 16-bit interleaved |
| w_cfg | input | WW | Full wait count |
| s_cfg | input | 1 | Short wait count (0 or 1) |
| beat_wait | output | WW | Wait count of the current beat |
| decode_cycle | output | 1 | Current cycle is the address-decode cycle |
| beat_done | output | 1 | Last (data) cycle of a beat |
| burst_done | output | 1 | Fill or run has finished |

## Verification
The block accepts a request on a clock edge. The first beat is visible in the next cycle, and `decode_cycle` is high there for the first beat of a fill or run. A beat then lasts decode + wait + 1 cycles. The next beat starts in the cycle after `beat_done`, and `burst_done` comes one cycle after the final `beat_done`. The bench samples on falling edges and counts cycles from the accepting edge. At each `beat_done` it compares the beat's measured length and `beat_wait` with values from its own wait function. It checks `burst_done` exactly one cycle later. During beats it scrambles `req` and the configuration inputs, so that a capture fault shows up as a wrong length or count.

// File: rtl/rws_pkg.sv
package rws_pkg;
  // Port organisations selected by port_mode.
  typedef enum logic [1:0] {
    RWS_PORT_N8  = 2'b00,
    RWS_PORT_N16 = 2'b01,
    RWS_PORT_ILV = 2'b10,
    RWS_PORT_IL2 = 2'b11
  } rws_port_e;

  function automatic logic rws_is_ilv(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/rws_wait_calc.sv
module rws_wait_calc #(
  parameter int WW = 4,
  parameter int PW = 3
) (
  input  logic          ilv,
  input  logic          burst,
  input  logic [PW-1:0] pos,
  input  logic [WW-1:0] w,
  input  logic          s,
  output logic [WW-1:0] wait_o
);
  localparam int DW = WW + 2;  // room for a negative difference

  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] floor_v;

  always_comb begin
    diff    = $signed({2'b00, w}) - $signed({{(DW-1){1'b0}}, s})
              - $signed({{(DW-1){1'b0}}, 1'b1});
    floor_v = burst ? $signed({{(DW-1){1'b0}}, 1'b1})
                    : $signed({{(DW-1){1'b0}}, s});
    if (!ilv || pos == '0)
      wait_o = w;
    else if (pos[0])
      wait_o = {{(WW-1){1'b0}}, s};
    else if (diff < floor_v)
      wait_o = floor_v[WW-1:0];
    else
      wait_o = diff[WW-1:0];
  end
endmodule

// File: rtl/rws_beat_timer.sv
module rws_beat_timer #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_dec,
  input  logic [WW-1:0] start_wait,
  output logic          decode_o,
  output logic          done_o,
  output logic [WW-1:0] wait_o
);
  localparam int CW = WW + 1;

  logic [CW-1:0] rem_q;
  logic [CW-1:0] load_v;

  assign load_v = CW'(start_wait) + CW'(start_dec);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      decode_o <= 1'b0;
      done_o   <= 1'b0;
      wait_o   <= '0;
    end else if (start) begin
      rem_q    <= load_v;
      decode_o <= start_dec;
      done_o   <= (load_v == '0);
      wait_o   <= start_wait;
    end else if (rem_q != '0) begin
      rem_q    <= rem_q - CW'(1);
      decode_o <= 1'b0;
      done_o   <= (rem_q == CW'(1));
    end else begin
      decode_o <= 1'b0;
      done_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/rom_wait_sequencer.sv
module rom_wait_sequencer #(
  parameter int AW           = 16,
  parameter int WW           = 4,
  parameter int NARROW_BEATS = 16,
  parameter int WIDE_BEATS   = 8,
  parameter int ILV_GROUP    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          is_instr,
  input  logic          cache_en,
  input  logic          cache_miss,
  input  logic          seq,
  input  logic [1:0]    port_mode,
  input  logic [WW-1:0] w_cfg,
  input  logic          s_cfg,
  output logic [WW-1:0] beat_wait,
  output logic          decode_cycle,
  output logic          beat_done,
  output logic          burst_done
);
  import rws_pkg::*;

  localparam int PW = (ILV_GROUP > 1) ? $clog2(ILV_GROUP) : 1;

  // Captured request
  logic          active_q;
  logic          burst_q;
  logic          ilv_q;
  logic [WW-1:0] w_q;
  logic          s_q;
  logic [AW-1:0] ptr_q;   // line-relative index for fills, address for runs
  logic [AW-1:0] last_q;  // final index of a fill
  logic          burst_done_q;

  // Next-beat selection
  logic          take, adv, fin, start, last_now;
  logic          req_burst;
  logic [AW-1:0] req_last;
  logic [AW-1:0] nxt_ptr;
  logic          nxt_ilv, nxt_burst, nxt_s;
  logic [WW-1:0] nxt_w;
  logic [WW-1:0] nxt_wait;

  always_comb begin
    req_burst = is_instr & cache_en & cache_miss;
    if (rws_is_ilv(port_mode))       req_last = AW'(ILV_GROUP - 1);
    else if (port_mode == RWS_PORT_N16) req_last = AW'(WIDE_BEATS - 1);
    else                             req_last = AW'(NARROW_BEATS - 1);

    last_now = burst_q ? (ptr_q == last_q) : !seq;
    take     = !active_q & req;
    adv      = active_q & beat_done & !last_now;
    fin      = active_q & beat_done & last_now;
    start    = take | adv;

    nxt_ilv   = take ? rws_is_ilv(port_mode) : ilv_q;
    nxt_burst = take ? req_burst : burst_q;
    nxt_w     = take ? w_cfg : w_q;
    nxt_s     = take ? s_cfg : s_q;
    if (take) nxt_ptr = req_burst ? '0 : addr;
    else      nxt_ptr = ptr_q + AW'(1);
  end

  rws_wait_calc #(.WW(WW), .PW(PW)) u_calc (
    .ilv    (nxt_ilv),
    .burst  (nxt_burst),
    .pos    (nxt_ptr[PW-1:0]),
    .w      (nxt_w),
    .s      (nxt_s),
    .wait_o (nxt_wait)
  );

  rws_beat_timer #(.WW(WW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_dec  (take),
    .start_wait (nxt_wait),
    .decode_o   (decode_cycle),
    .done_o     (beat_done),
    .wait_o     (beat_wait)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q     <= 1'b0;
      burst_q      <= 1'b0;
      ilv_q        <= 1'b0;
      w_q          <= '0;
      s_q          <= 1'b0;
      ptr_q        <= '0;
      last_q       <= '0;
      burst_done_q <= 1'b0;
    end else begin
      burst_done_q <= fin;
      if (take) begin
        active_q <= 1'b1;
        burst_q  <= req_burst;
        ilv_q    <= rws_is_ilv(port_mode);
        w_q      <= w_cfg;
        s_q      <= s_cfg;
        last_q   <= req_last;
        ptr_q    <= nxt_ptr;
      end else if (adv) begin
        ptr_q    <= nxt_ptr;
      end else if (fin) begin
        active_q <= 1'b0;
      end
    end
  end

  assign burst_done = burst_done_q;
endmodule

// File: rtl/rws_checker.sv
module rws_checker #(
  parameter int WW = 4,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          active,
  input logic          burst,
  input logic          ilv,
  input logic          s,
  input logic [PW-1:0] pos,
  input logic [WW-1:0] beat_wait,
  input logic          decode_cycle,
  input logic          beat_done,
  input logic          burst_done
);
  assert_decode_single_R4: assert property (@(posedge clk) disable iff (rst)
    decode_cycle |=> !decode_cycle);

  assert_wait_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(beat_done)) |-> $stable(beat_wait));

  assert_odd_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (active && ilv && pos[0]) |-> (beat_wait == {{(WW-1){1'b0}}, s}));

  assert_fill_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (active && ilv && burst && !pos[0] && pos != '0) |-> (beat_wait >= 1));

  assert_plain_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (active && ilv && !burst && !pos[0] && pos != '0) |-> (beat_wait >= {{(WW-1){1'b0}}, s}));

  assert_end_follows_R9: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> ($past(beat_done) && !active));

  assert_end_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !active |-> (!beat_done && !decode_cycle));
endmodule

bind rom_wait_sequencer rws_checker #(.WW(WW), .PW(PW)) u_rws_checker (
  .clk          (clk),
  .rst          (rst),
  .active       (active_q),
  .burst        (burst_q),
  .ilv          (ilv_q),
  .s            (s_q),
  .pos          (ptr_q[PW-1:0]),
  .beat_wait    (beat_wait),
  .decode_cycle (decode_cycle),
  .beat_done    (beat_done),
  .burst_done   (burst_done)
);

// File: tb/tb_rom_wait_sequencer.sv
`timescale 1ns/1ps
module tb_rom_wait_sequencer;
  localparam int AW = 16;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          is_instr = 1'b0, cache_en = 1'b0, cache_miss = 1'b0, seq = 1'b0;
  logic [1:0]    port_mode = 2'b00;
  logic [WW-1:0] w_cfg = '0;
  logic          s_cfg = 1'b0;
  logic [WW-1:0] beat_wait;
  logic          decode_cycle, beat_done, burst_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rom_wait_sequencer #(.AW(AW), .WW(WW)) dut (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .is_instr(is_instr),
    .cache_en(cache_en), .cache_miss(cache_miss), .seq(seq),
    .port_mode(port_mode), .w_cfg(w_cfg), .s_cfg(s_cfg),
    .beat_wait(beat_wait), .decode_cycle(decode_cycle),
    .beat_done(beat_done), .burst_done(burst_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_wait(bit ilv, bit fill, int pos, int w, int s);
    int mid, lo;
    if (!ilv || pos == 0) return w;
    if (pos % 2 == 1) return s;
    mid = w - s - 1;
    lo  = fill ? 1 : s;
    return (mid < lo) ? lo : mid;
  endfunction

  // One transaction; nrun = beats of a plain run (ignored for fills)
  task automatic txn(input int mode, input bit instr, input bit cen, input bit miss,
                     input int a, input int w, input int s, input int nrun, input string tag);
    bit fill, ilv;
    int nb, cnt;
    fill = instr && cen && miss;
    ilv  = (mode >= 2);
    nb   = fill ? ((mode == 0) ? 16 : 8) : nrun;
    @(negedge clk);
    port_mode = mode[1:0]; is_instr = instr; cache_en = cen; cache_miss = miss;
    addr = a[AW-1:0]; w_cfg = w[WW-1:0]; s_cfg = s[0]; req = 1'b1; seq = 1'b0;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < nb; i++) begin
      int ew, pos, dec;
      pos = fill ? (i % 8) : ((a + i) % 8);
      ew  = exp_wait(ilv, fill, pos, w, s);
      dec = (i == 0) ? 1 : 0;
      cnt = 1;
      check(decode_cycle == dec[0], {tag, " R4 decode"}, decode_cycle, dec);
      while (!beat_done && cnt < 40) begin
        // scramble inputs while busy (R10)
        req = $urandom_range(0, 1);
        port_mode = 2'($urandom_range(0, 3));
        w_cfg = WW'($urandom_range(0, 15));
        s_cfg = 1'($urandom_range(0, 1));
        addr = AW'($urandom);
        is_instr = 1'($urandom_range(0, 1));
        @(negedge clk);
        cnt++;
      end
      check(int'(beat_wait) == ew, {tag, " wait"}, int'(beat_wait), ew);
      check(cnt == dec + ew + 1, {tag, " R4 length"}, cnt, dec + ew + 1);
      check(burst_done == 1'b0, {tag, " R9 early end"}, burst_done, 0);
      if (cnt >= 40) return;
      req = 1'b0;
      seq = fill ? 1'($urandom_range(0, 1)) : (i < nb - 1);
      if (i == nb - 1) req = 1'b0;
      @(negedge clk);
    end
    check(burst_done == 1'b1 && beat_done == 1'b0, {tag, " R9 end pulse"}, burst_done, 1);
    seq = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!beat_done && !decode_cycle && !burst_done && beat_wait == '0,
          "R11 reset", {beat_done, decode_cycle, burst_done}, 0);
    @(negedge clk);
    check(!beat_done && !decode_cycle && !burst_done, "R11 idle",
          {beat_done, decode_cycle, burst_done}, 0);

    txn(0, 1, 1, 1, 0,   3, 0, 1, "R1 narrow fill");
    txn(1, 1, 1, 1, 12,  0, 1, 1, "R2 wide fill w0");
    txn(1, 1, 1, 1, 0,   5, 0, 1, "R2 wide fill");
    txn(1, 0, 1, 1, 40,  2, 1, 5, "R3 data run");
    txn(0, 1, 0, 1, 3,   4, 0, 1, "R3 uncached fetch");
    txn(1, 1, 1, 0, 9,   1, 0, 2, "R3 hit fetch");
    txn(2, 1, 1, 1, 0,   1, 1, 1, "R6 fill clamp");
    txn(2, 1, 1, 1, 0,   0, 0, 1, "R6 fill w0");
    txn(2, 1, 1, 1, 0,   9, 1, 1, "R5 fill pattern");
    txn(2, 0, 0, 0, 0,   1, 1, 8, "R7 plain clamp s");
    txn(2, 0, 0, 0, 0,   0, 0, 8, "R7 plain clamp 0");
    txn(3, 0, 1, 1, 5,   7, 1, 10, "R8 partial then wrap");
    txn(2, 1, 0, 0, 3,   6, 0, 1, "R9 stop anywhere");
    txn(2, 0, 0, 0, 14,  2, 1, 3, "R9 short run");

    for (int k = 0; k < 60; k++) begin
      txn($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), $urandom_range(0, 65535), $urandom_range(0, 15),
          $urandom_range(0, 1), $urandom_range(1, 12), "R10 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule